// File: doc/BRIEF.md
# Multi-Frequency Square Wave Sequencer

This block drives one digital output with a repeating program of square-wave segments. Every segment has three settings: a frequency in hertz, a high time in nanoseconds and a number of full periods. All three are fixed when the design is built. The clock frequency parameter turns the frequency and the high time into clock-tick counts during elaboration. No divider exists in the hardware. The block plays each segment for its period count and then moves to the next one. After the last segment it starts again at the first, with no idle ticks in between.

The settings are not validated. A high time that reaches or passes the period keeps the output high for the whole segment. An enable input pauses the sequence: the output goes low and the position is held until enable returns. A one-clock strobe marks the first tick of every segment. Downstream logic can use it to learn which tone is playing.

Top module: `sqw_sequencer`

## Requirements
- R1: One clock with reset high returns the block to segment 0, period 0, tick 0. On the first enabled clock after reset, the output equals 1 if segment 0 has a nonzero high count, and the strobe is 1.
- R2: A segment has period ticks P = floor(CLK_HZ / SEG_HZ) and high ticks H = floor(SEG_HIGH_NS * CLK_HZ / 1e9). Every period starts with H enabled clocks at output 1 and then P - H enabled clocks at output 0.
- R3: A segment plays exactly SEG_CYCLES full periods and is then followed by the next segment in index order.
- R4: When H >= P, the output stays 1 on every enabled clock of that segment.
- R5: After the final period of the last segment, the next enabled clock is tick 0 of segment 0, with no gap.
- R6: The strobe is 1 only on an enabled clock at tick 0 of period 0 of a segment, and is 0 on all other clocks.
- R7: While enable is 0, output and strobe are 0 and the position is frozen. When enable returns, the sequence resumes at the tick where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low pauses and silences the output |
| wave | output | 1 | Square-wave output |
| seg_strobe | output | 1 | One-clock pulse on the first tick of each segment |

## Verification
The bench follows the sequence with its own position counters and compares both outputs on every clock. A wrong period or high-tick conversion moves the falling edge or the period boundary. That error appears as a mismatch within one period. The third segment has a high time longer than its period. A design that wraps or clips the compare would drop the output low there. Random pauses of the enable input catch two faults: a design that keeps counting while disabled drifts out of phase, and one that drives the output or strobe while paused is flagged at once. A full enabled loop, the wrap back to segment 0 and a reset taken in mid-sequence target a missing or extra strobe, an off-by-one period count and a lost restart position.

// File: rtl/sqw_sequencer.sv
module sqw_sequencer #(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int NSEG = 3,
  parameter int unsigned SEG_HZ      [NSEG] = '{242_000, 23_000, 100_000},
  parameter int unsigned SEG_HIGH_NS [NSEG] = '{1_000, 20_000, 12_000},
  parameter int unsigned SEG_CYCLES  [NSEG] = '{4, 2, 3},
  parameter int CNT_W = 32,
  parameter int CYC_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic wave,
  output logic seg_strobe
);

  localparam int SEG_W = (NSEG > 1) ? $clog2(NSEG) : 1;
  localparam logic [63:0] NS_PER_S = 64'd1_000_000_000;

  logic [CNT_W-1:0] per_t  [NSEG];
  logic [CNT_W-1:0] high_t [NSEG];
  logic [CYC_W-1:0] ncyc_t [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign per_t[g]  = CNT_W'(64'(CLK_HZ) / 64'(SEG_HZ[g]));
    assign high_t[g] = CNT_W'(64'(SEG_HIGH_NS[g]) * 64'(CLK_HZ) / NS_PER_S);
    assign ncyc_t[g] = CYC_W'(SEG_CYCLES[g]);
  end

  logic [SEG_W-1:0] seg_q;
  logic [CNT_W-1:0] tick_q;
  logic [CYC_W-1:0] cyc_q;

  logic [CNT_W-1:0] per_cur, high_cur;
  logic [CYC_W-1:0] ncyc_cur;
  logic last_tick, last_cyc, last_seg;

  assign per_cur   = per_t[seg_q];
  assign high_cur  = high_t[seg_q];
  assign ncyc_cur  = ncyc_t[seg_q];
  assign last_tick = (tick_q == per_cur - CNT_W'(1));
  assign last_cyc  = (cyc_q == ncyc_cur - CYC_W'(1));
  assign last_seg  = (seg_q == SEG_W'(NSEG - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q  <= '0;
      tick_q <= '0;
      cyc_q  <= '0;
    end else if (en) begin
      if (last_tick) begin
        tick_q <= '0;
        if (last_cyc) begin
          cyc_q <= '0;
          seg_q <= last_seg ? '0 : seg_q + SEG_W'(1);
        end else begin
          cyc_q <= cyc_q + CYC_W'(1);
        end
      end else begin
        tick_q <= tick_q + CNT_W'(1);
      end
    end
  end

  assign wave       = en & (tick_q < high_cur);
  assign seg_strobe = en & (tick_q == '0) & (cyc_q == '0);

endmodule

// File: rtl/sqw_sequencer_chk.sv
module sqw_sequencer_chk #(
  parameter int SEG_W = 2,
  parameter int CNT_W = 32,
  parameter int CYC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             wave,
  input logic             seg_strobe,
  input logic [SEG_W-1:0] seg_q,
  input logic [CNT_W-1:0] tick_q,
  input logic [CYC_W-1:0] cyc_q
);

  // R1
  reset_home_chk: assert property (@(posedge clk)
    $fell(rst) |-> (seg_q == '0 && tick_q == '0 && cyc_q == '0));

  // R7
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |-> (!wave && !seg_strobe));

  // R7
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(seg_q) && $stable(tick_q) && $stable(cyc_q)));

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    seg_strobe |=> !seg_strobe);

  // R3
  seg_step_chk: assert property (@(posedge clk) disable iff (rst)
    (seg_q != $past(seg_q)) |-> (tick_q == '0 && cyc_q == '0));

  // R2
  rise_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(wave) && $past(en)) |-> (tick_q == '0));

endmodule

bind sqw_sequencer sqw_sequencer_chk #(.SEG_W(SEG_W), .CNT_W(CNT_W), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .wave(wave), .seg_strobe(seg_strobe),
  .seg_q(seg_q), .tick_q(tick_q), .cyc_q(cyc_q)
);

// File: tb/test_sqw_sequencer.sv
module test_sqw_sequencer;

  localparam longint CLK = 50_000_000;
  localparam int NS = 3;
  localparam longint HZ  [NS] = '{242_000, 23_000, 100_000};
  localparam longint HNS [NS] = '{1_000, 20_000, 12_000};
  localparam int     NC  [NS] = '{4, 2, 3};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic wave, seg_strobe;

  int checks = 0;
  int errors = 0;
  int m_seg = 0;
  longint m_tick = 0;
  int m_cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sqw_sequencer i_sqw_sequencer (
    .clk(clk), .rst(rst), .en(en), .wave(wave), .seg_strobe(seg_strobe)
  );

  function automatic longint per_of(int s);
    return CLK / HZ[s];
  endfunction

  function automatic longint high_of(int s);
    return (HNS[s] * CLK) / 64'd1_000_000_000;
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b (seg %0d cyc %0d tick %0d)",
               req, what, act, exp, m_seg, m_cyc, m_tick);
    end
  endtask

  task automatic model_advance();
    if (m_tick == per_of(m_seg) - 1) begin
      m_tick = 0;
      if (m_cyc == NC[m_seg] - 1) begin
        m_cyc = 0;
        m_seg = (m_seg == NS - 1) ? 0 : m_seg + 1;
      end else m_cyc++;
    end else m_tick++;
  endtask

  task automatic step(bit e, string force_tag, output logic got_strobe);
    logic ew, es;
    string tw, ts;
    @(negedge clk);
    en = e;
    #1;
    ew = e && (m_tick < high_of(m_seg));
    es = e && (m_tick == 0) && (m_cyc == 0);
    if (force_tag != "") begin tw = force_tag; ts = force_tag; end
    else if (!e) begin tw = "R7"; ts = "R7"; end
    else begin
      tw = (high_of(m_seg) >= per_of(m_seg)) ? "R4" : "R2";
      ts = es ? ((m_seg == 0) ? "R5" : "R3") : "R6";
    end
    check(tw, "wave", wave, ew);
    check(ts, "strobe", seg_strobe, es);
    got_strobe = seg_strobe;
    if (e) model_advance();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    en = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    en = 1'b0;
    m_seg = 0; m_tick = 0; m_cyc = 0;
  endtask

  initial begin
    logic s;
    int nstrobe;
    int loop_len;
    void'($urandom(32'd2024));
    do_reset();

    step(1'b1, "R1", s);

    loop_len = 0;
    for (int i = 0; i < NS; i++) loop_len += NC[i] * int'(per_of(i));
    nstrobe = 1;
    for (int i = 1; i < loop_len; i++) begin
      step(1'b1, "", s);
      if (s) nstrobe++;
    end
    checks++;
    if (nstrobe != NS) begin
      errors++;
      $display("FAIL R6 strobes per loop: actual %0d expected %0d", nstrobe, NS);
    end
    step(1'b1, "R5", s);
    checks++;
    if (s !== 1'b1) begin
      errors++;
      $display("FAIL R5 wrap strobe: actual %b expected 1", s);
    end

    for (int i = 0; i < 200; i++) step(1'b0, "R7", s);

    for (int i = 0; i < 15000; i++) step(($urandom % 4) != 0, "", s);

    do_reset();
    step(1'b0, "R7", s);
    step(1'b1, "R1", s);
    for (int i = 0; i < 3000; i++) step(($urandom % 3) != 0, "", s);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule